// File: doc/BRIEF.md
# Serial-bus slave for a 512-byte paged memory

This block is the target side of a two-wire serial bus (I2C) in front of a 512 x 8 storage array. The array is held in registers here. The block samples SCL and SDA with the system clock and finds START and STOP conditions. It decodes the device byte and follows the byte protocol: a word-address phase, byte and paged writes, and current, random and streaming reads. It signals acknowledge by pulling SDA low through a single open-drain control output.

Writes do not go straight into the array. Incoming bytes are staged in a buffer one page wide. A STOP then opens an internal write period whose length is a parameter. The staged bytes are moved into the array once that period has run out. While the period lasts the block ignores the bus entirely, so a master can poll it with address bytes until an acknowledge comes back. A 9-bit pointer holds the location after the last one touched, and it is kept between transfers.

Top module: `i2c_page_mem`

## Requirements
- R1: A device byte whose bits 7:4 are 1010 is acknowledged, and bits 3:2 of that byte have no effect. Any other value in bits 7:4 is not acknowledged, and the block stays silent until the next START or STOP.
- R2: The acknowledge is given by holding SDA low during the ninth SCL pulse. It follows a matching device byte and, in write mode (bit 0 = 0), every later byte as well.
- R3: A write takes effect only after a STOP and after a write period of WR_CYCLES clocks. The written data can then be read back.
- R4: A paged write keeps address bits 8:4 fixed and steps bits 3:0 by one per data byte. The 17th byte and any later byte wrap within the 16-byte page and overwrite earlier data.
- R5: While the write period is running, every START is ignored and nothing is acknowledged. Once the period ends, the device byte is acknowledged again.
- R6: A read-mode device byte (bit 0 = 1) returns the byte at the pointer, and its bit 1 is ignored. The pointer always names the location after the last one accessed: it wraps 9 bits on reads and wraps within the page on writes.
- R7: For a random read, a write-mode phase loads the pointer. The pointer is formed from bit 1 of the device byte (address bit 8) and the word-address byte (bits 7:0). A repeated START with a read-mode device byte then reads from that location.
- R8: Each master ACK during a read steps all 9 pointer bits, going from 0x1FF to 0x000. A master NACK ends the transfer and leaves SDA released.
- R9: A STOP that comes before any complete data byte has been received starts no write period.
- R10: A START or STOP in the middle of a byte abandons that byte and restarts the decoding of a device byte or returns to idle.
- R11: After reset SDA is released, the pointer is 0 and every array location reads 0.
- R12: The block changes SDA only while SCL is low, after a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 leaves the line released |

## Verification
A single byte write and an 18-byte paged write that starts near the top of a page are read back with random reads that cover the page and the bytes next to it. This separates the in-page wrap from a carry into bit 4. Current-address reads right after reset, after a write and after a 9-bit wrap at 0x1FF show whether the pointer follows the read rule or the write rule. Polls placed during and after the write period, a STOP issued right after the word address, and START or STOP cut into the middle of a byte separate the cases where a write is launched from those where it is not, and show that the bus resynchronises.

// File: rtl/i2cpm_pkg.sv
package i2cpm_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_TX, S_TXEND, S_MACK, S_LOAD, S_WAIT
  } st_e;

  typedef enum logic [1:0] {PH_DEV, PH_WADDR, PH_DATA} ph_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic scl;
    logic sda;
  } bus_ev_t;

endpackage

// File: rtl/i2cpm_bus_sense.sv
module i2cpm_bus_sense
  import i2cpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q, scl_s, sda_s;

  // idle bus level is high on both lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s = scl_sync[SYNC_STAGES-1];
  assign sda_s = sda_sync[SYNC_STAGES-1];

  always_comb begin
    ev_o.start = scl_s & scl_q & sda_q & ~sda_s;
    ev_o.stop  = scl_s & scl_q & ~sda_q & sda_s;
    ev_o.rise  = scl_s & ~scl_q;
    ev_o.fall  = ~scl_s & scl_q;
    ev_o.scl   = scl_s;
    ev_o.sda   = sda_s;
  end

endmodule

// File: rtl/i2cpm_wr_engine.sv
module i2cpm_wr_engine #(
  parameter int PAGE_BYTES = 16,
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int WR_CYCLES  = 500000,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [PAGE_W-1:0] wr_page_i,
  input  logic [OFS_W-1:0]  wr_ofs_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              go_i,
  output logic              busy_o,
  output logic              pending_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);

  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  typedef enum logic [1:0] {E_IDLE, E_TIME, E_COMMIT} eph_e;

  eph_e                          phase_q;
  logic [CNT_W-1:0]              tmr_q;
  logic [OFS_W-1:0]              idx_q;
  logic [PAGE_W-1:0]             page_q;
  logic [PAGE_BYTES-1:0]         vld_q;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= E_IDLE;
      tmr_q   <= '0;
      idx_q   <= '0;
      page_q  <= '0;
      vld_q   <= '0;
      buf_q   <= '0;
    end else begin
      if (clr_i && phase_q == E_IDLE) begin
        vld_q <= '0;
      end else if (wr_en_i) begin
        buf_q[wr_ofs_i] <= wr_data_i;
        vld_q[wr_ofs_i] <= 1'b1;
        page_q          <= wr_page_i;
      end
      case (phase_q)
        E_IDLE: if (go_i && pending_o) begin
          phase_q <= E_TIME;
          tmr_q   <= CNT_W'(WR_CYCLES - 1);
        end
        E_TIME: if (tmr_q == '0) begin
          phase_q <= E_COMMIT;
          idx_q   <= '0;
        end else begin
          tmr_q <= tmr_q - 1'b1;
        end
        default: begin
          vld_q[idx_q] <= 1'b0;
          idx_q        <= idx_q + 1'b1;
          if (idx_q == OFS_W'(PAGE_BYTES - 1)) phase_q <= E_IDLE;
        end
      endcase
    end
  end

  assign busy_o      = phase_q != E_IDLE;
  assign pending_o   = |vld_q;
  assign mem_we_o    = (phase_q == E_COMMIT) && vld_q[idx_q];
  assign mem_addr_o  = {page_q, idx_q};
  assign mem_wdata_o = buf_q[idx_q];

  // R4: all staged bytes of one write belong to a single page
  p_page_fixed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && pending_o && !clr_i) |-> (wr_page_i == page_q));

  // R3: a STOP with staged data opens the write period
  p_launch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && pending_o && !busy_o) |=> busy_o);

endmodule

// File: rtl/i2c_page_mem.sv
module i2c_page_mem
  import i2cpm_pkg::*;
#(
  parameter int         PAGE_BYTES  = 16,
  parameter int         WR_CYCLES   = 500000,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_ID      = 4'b1010
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);

  localparam int ADDR_W = 9;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;

  bus_ev_t ev;
  st_e     st_q;
  ph_e     ph_q;
  logic [2:0]        cnt_q;
  logic [7:0]        sh_q, tx_q, byte_w, rd_byte;
  logic              rw_q, a8_q, pull_q, ack_hi_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [DATA_W-1:0] mem_q [DEPTH];

  logic busy, pending, wr_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  i2cpm_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk_i (clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i), .ev_o(ev)
  );

  assign byte_w  = {sh_q[6:0], ev.sda};
  assign rd_byte = mem_q[ptr_q];
  assign wr_en   = (st_q == S_RX) && (ph_q == PH_DATA) && ev.rise && (cnt_q == 3'd7);

  i2cpm_wr_engine #(
    .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_CYCLES(WR_CYCLES)
  ) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (ev.start & ~busy),
    .wr_en_i    (wr_en),
    .wr_page_i  (ptr_q[ADDR_W-1:OFS_W]),
    .wr_ofs_i   (ptr_q[OFS_W-1:0]),
    .wr_data_i  (byte_w),
    .go_i       (ev.stop & ~busy),
    .busy_o     (busy),
    .pending_o  (pending),
    .mem_we_o   (mem_we),
    .mem_addr_o (mem_addr),
    .mem_wdata_o(mem_wdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      ph_q     <= PH_DEV;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      a8_q     <= 1'b0;
      pull_q   <= 1'b0;
      ack_hi_q <= 1'b0;
      ptr_q    <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (mem_we) mem_q[mem_addr] <= mem_wdata;
      if (busy || ev.stop) begin
        // write period ignores the bus; STOP returns to idle
        st_q     <= S_IDLE;
        pull_q   <= 1'b0;
        ack_hi_q <= 1'b0;
      end else if (ev.start) begin
        st_q     <= S_RX;
        ph_q     <= PH_DEV;
        cnt_q    <= '0;
        pull_q   <= 1'b0;
        ack_hi_q <= 1'b0;
      end else begin
        case (st_q)
          S_RX: if (ev.rise) begin
            sh_q  <= byte_w;
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              case (ph_q)
                PH_DEV: if (byte_w[7:4] == DEV_ID) begin
                  rw_q <= byte_w[0];
                  if (!byte_w[0]) a8_q <= byte_w[1];
                  st_q <= S_ACK;
                end else begin
                  st_q <= S_WAIT;
                end
                PH_WADDR: begin
                  ptr_q <= {a8_q, byte_w};
                  st_q  <= S_ACK;
                end
                default: begin
                  ptr_q[OFS_W-1:0] <= ptr_q[OFS_W-1:0] + 1'b1;
                  st_q             <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: if (ev.fall) begin
            if (!ack_hi_q) begin
              pull_q   <= 1'b1;
              ack_hi_q <= 1'b1;
            end else begin
              ack_hi_q <= 1'b0;
              cnt_q    <= '0;
              if (ph_q == PH_DEV && rw_q) begin
                tx_q   <= rd_byte;
                ptr_q  <= ptr_q + 1'b1;
                pull_q <= ~rd_byte[7];
                st_q   <= S_TX;
              end else begin
                pull_q <= 1'b0;
                st_q   <= S_RX;
                ph_q   <= (ph_q == PH_DEV) ? PH_WADDR : PH_DATA;
              end
            end
          end
          S_TX: if (ev.rise) begin
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) st_q <= S_TXEND;
          end else if (ev.fall) begin
            tx_q   <= {tx_q[6:0], 1'b0};
            pull_q <= ~tx_q[6];
          end
          S_TXEND: if (ev.fall) begin
            pull_q <= 1'b0;
            st_q   <= S_MACK;
          end
          S_MACK: if (ev.rise) st_q <= ev.sda ? S_WAIT : S_LOAD;
          S_LOAD: if (ev.fall) begin
            tx_q   <= rd_byte;
            ptr_q  <= ptr_q + 1'b1;
            pull_q <= ~rd_byte[7];
            cnt_q  <= '0;
            st_q   <= S_TX;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;

  // R12: the line is only ever pulled while SCL is low
  p_drive_low_scl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_q) |-> !ev.scl);

  // R5: no acknowledge or data while the write period runs
  p_busy_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !pull_q);

  // R9: STOP without a staged byte never starts a write period
  p_no_empty_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev.stop && !busy && !pending) |=> !busy);

endmodule

// File: tb/sim_i2c_page_mem.sv
module sim_i2c_page_mem;

  localparam int WR = 2000;
  localparam int Q  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull, sda_line;
  int tests = 0, fails = 0;
  logic [7:0] mdl [512];
  logic [8:0] mptr = '0;
  logic [7:0] exp_q[$], act_q[$];
  string      req_q[$];

  always #10 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  i2c_page_mem #(.WR_CYCLES(WR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_pull_o(sda_pull)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic qd(); repeat (Q) @(negedge clk); endtask
  task automatic start_c(); m_sda = 1; qd(); m_scl = 1; qd(); m_sda = 0; qd(); m_scl = 0; qd(); endtask
  task automatic stop_c(); m_sda = 0; qd(); m_scl = 1; qd(); m_sda = 1; qd(); qd(); endtask
  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; qd(); m_scl = 1; qd(); s = sda_line; qd(); m_scl = 0; qd();
  endtask
  task automatic send_bits(input logic [7:0] b, input int n);
    logic s;
    for (int i = 7; i > 7 - n; i--) clk_bit(b[i], s);
  endtask
  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic s;
    send_bits(b, 8);
    clk_bit(1'b1, s);
    ack = !s;
  endtask
  task automatic recv_byte(input bit mack);
    logic s;
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); v[i] = s; end
    clk_bit(!mack, s);
    act_q.push_back(v);
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] a, e;
      string r;
      a = act_q.pop_front(); e = exp_q.pop_front(); r = req_q.pop_front();
      chk(a == e, r, a, e);
    end
  end

  task automatic expect_rd(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(mdl[mptr]); req_q.push_back(req);
      mptr = mptr + 9'd1;
      recv_byte(i != n - 1);
    end
  endtask

  task automatic write_seq(input logic [8:0] a, input int n, input logic [7:0] base, input string req);
    bit ack;
    start_c();
    send_byte(8'hA0 | {6'd0, a[8], 1'b0}, ack); chk(ack, {req, " R2 dev ack"}, ack, 1);
    send_byte(a[7:0], ack); chk(ack, {req, " R2 addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(base + 8'(i), ack); chk(ack, {req, " R2 data ack"}, ack, 1);
      mdl[{a[8:4], 4'(a[3:0] + i)}] = base + 8'(i);
    end
    mptr = {a[8:4], 4'(a[3:0] + n)};
    stop_c();
  endtask

  task automatic rand_read(input logic [8:0] a, input int n, input string req);
    bit ack;
    start_c();
    send_byte(8'hA0 | {6'd0, a[8], 1'b0}, ack); chk(ack, {req, " R7 dev ack"}, ack, 1);
    send_byte(a[7:0], ack); chk(ack, {req, " R7 addr ack"}, ack, 1);
    start_c();
    send_byte(8'hA1, ack); chk(ack, {req, " R6 read dev ack"}, ack, 1);
    mptr = a;
    expect_rd(n, req);
    stop_c();
  endtask

  task automatic cur_read(input int n, input string req);
    bit ack;
    start_c();
    send_byte(8'hA1, ack); chk(ack, {req, " R6 read dev ack"}, ack, 1);
    expect_rd(n, req);
    stop_c();
  endtask

  task automatic poll(input bit exp_ack, input string req);
    bit ack;
    start_c();
    send_byte(8'hA0, ack); chk(ack == exp_ack, req, ack, exp_ack);
    stop_c();
  endtask

  task automatic wait_wr(); repeat (WR + 100) @(negedge clk); endtask

  initial begin
    repeat (Q * 400000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R0 act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit ack;
    for (int i = 0; i < 512; i++) mdl[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_line == 1'b1, "R11 SDA released after reset", sda_line, 1);
    cur_read(1, "R11 pointer zero");
    cur_read(1, "R6 pointer step");

    // byte write, then busy behaviour
    write_seq(9'h040, 1, 8'h5A, "R3 byte write");
    poll(1'b0, "R5 poll while busy");
    start_c();
    send_byte(8'hA0, ack); chk(!ack, "R5 write ignored while busy", ack, 0);
    send_byte(8'h50, ack); chk(!ack, "R5 addr ignored while busy", ack, 0);
    stop_c();
    wait_wr();
    poll(1'b1, "R5 ack after period");
    rand_read(9'h040, 1, "R3 readback");
    rand_read(9'h050, 1, "R5 busy write had no effect");
    cur_read(1, "R6 current after read");

    // page write crossing the page end, with wrap overwrite
    write_seq(9'h13C, 18, 8'h80, "R4 page write");
    wait_wr();
    cur_read(1, "R6 pointer after page write");
    rand_read(9'h12F, 18, "R4 page contents");

    // 9-bit wrap on sequential read
    write_seq(9'h000, 1, 8'h11, "R8 setup");
    wait_wr();
    write_seq(9'h1FF, 1, 8'hEE, "R8 setup");
    wait_wr();
    rand_read(9'h1FE, 3, "R8 wrap read");
    cur_read(1, "R8 pointer after wrap");
    chk(sda_line == 1'b1, "R8 SDA released after NACK", sda_line, 1);

    // device byte decode
    start_c(); send_byte(8'hB0, ack); chk(!ack, "R1 wrong id", ack, 0); stop_c();
    start_c(); send_byte(8'hAC, ack); chk(ack, "R1 bits 3:2 ignored", ack, 1); stop_c();

    // STOP with no data byte
    start_c(); send_byte(8'hA0, ack); send_byte(8'h20, ack); stop_c();
    mptr = 9'h020;
    poll(1'b1, "R9 no write period");

    // STOP mid-byte after address 0x040
    start_c(); send_byte(8'hA0, ack); send_byte(8'h40, ack);
    send_bits(8'hFF, 4); stop_c();
    mptr = 9'h040;
    poll(1'b1, "R10 stop mid-byte no write");
    // START mid-byte, then current read of 0x040
    start_c(); send_byte(8'hA0, ack); send_bits(8'h00, 3);
    start_c(); send_byte(8'hA1, ack); chk(ack, "R10 resync after start", ack, 1);
    expect_rd(1, "R10 data intact");
    stop_c();

    repeat (50) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule